// File: doc/BRIEF.md
# DMA Ready Strobe Generator for a Serial Port FIFO

This block drives the two active-low DMA request pins that sit beside the receive and transmit FIFOs of a 16550-class serial port. It does not hold characters itself. It watches how many characters each FIFO holds, the receive character-timeout flag, and three control fields. The control fields are the FIFO enable bit, the DMA signalling select bit and the two-bit receive trigger selector. From these it decides when a DMA engine may pull received data or push more data to send.

Two signalling styles are supported. In the level style, each pin simply reflects whether there is work to do: received data is present, or the transmit side is empty. In the latched style, each pin has separate conditions that assert it and release it, and it keeps its state between those points. The receive pin asserts at the trigger threshold or on a timeout and releases only when the receive FIFO is drained. The transmit pin asserts when the transmit FIFO is empty and releases only when it is completely full. A DMA burst can therefore run to completion instead of stopping after each character.

Top module: `dma_rdy_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both `rx_rdy_n` and `tx_rdy_n` are high after that edge.
- R2: The latched style is used only when `fifo_en` = 1 and `dma_mode` = 1. Every other combination (for example `fifo_en` = 0 with `dma_mode` = 1) uses the level style.
- R3: In the level style, `rx_rdy_n` is low exactly when `rx_count` is not zero.
- R4: In the latched style, `rx_rdy_n` goes low once `rx_count` reaches the trigger level. The level is selected by `rx_trig_sel`: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14 characters. Below the level it keeps its previous state.
- R5: In the latched style, `rx_rdy_n` goes low when `rx_timeout` is 1 and `rx_count` is not zero, even if the count is below the trigger level.
- R6: In the latched style, `rx_rdy_n` stays low while `rx_count` is non-zero. It returns high when `rx_count` is 0, and an empty FIFO takes precedence over `rx_timeout`.
- R7: In the level style, `tx_rdy_n` is low exactly when `tx_count` is 0.
- R8: In the latched style, `tx_rdy_n` goes low when `tx_count` is 0 and goes high when `tx_count` equals the FIFO depth (16). For any count in between it keeps its previous state.
- R9: Both pins are registered. A change of inputs appears on the pins after the next rising clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_mode | input | 1 | Selects the latched signalling style when FIFOs are enabled |
| rx_trig_sel | input | 2 | Receive trigger level selector |
| rx_count | input | CNT_W (5) | Characters held in the receive FIFO or holding register |
| rx_timeout | input | 1 | Receive character timeout has expired |
| tx_count | input | CNT_W (5) | Characters held in the transmit FIFO or holding register |
| rx_rdy_n | output | 1 | Receive DMA ready, active low |
| tx_rdy_n | output | 1 | Transmit DMA ready, active low |

## Verification
The bench builds the block with the default depth of 16 and 5-bit occupancy counts. At that depth all four trigger codes, including the 14-character level, lie below the full mark, and an occupancy of exactly 16 can be driven to exercise the transmit release. The 5-bit counts also allow the counts just below the trigger and full points to be driven, so the hold behaviour between the assert and release points can be observed on the pins.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;

    localparam int RX_PIN   = 0;
    localparam int TX_PIN   = 1;
    localparam int NUM_PINS = 2;

    typedef enum logic {
        SIG_LEVEL = 1'b0,
        SIG_LATCH = 1'b1
    } sig_style_e;

    // Per-pin request: lvl drives level style, set/clr drive latched style
    typedef struct packed {
        logic lvl;
        logic set;
        logic clr;
    } pin_req_t;

    function automatic sig_style_e style_of(input logic fen, input logic dsel);
        return (fen && dsel) ? SIG_LATCH : SIG_LEVEL;
    endfunction

    function automatic int unsigned trig_chars(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/dma_rdy_rx_cond.sv
module dma_rdy_rx_cond
    import dma_rdy_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_timeout,
    input  logic [1:0]       rx_trig_sel,
    output pin_req_t         req
);
    logic [CNT_W:0] level;
    logic           has_data;

    always_comb begin
        level    = (CNT_W+1)'(trig_chars(rx_trig_sel));
        has_data = (rx_count != '0);
        req.lvl  = has_data;
        req.clr  = !has_data;
        req.set  = ({1'b0, rx_count} >= level) || rx_timeout;
    end
endmodule

// File: rtl/dma_rdy_tx_cond.sv
module dma_rdy_tx_cond
    import dma_rdy_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input  logic [CNT_W-1:0] tx_count,
    output pin_req_t         req
);
    localparam logic [CNT_W:0] FULL_MARK = (CNT_W+1)'(FIFO_DEPTH);

    logic empty;

    always_comb begin
        empty   = (tx_count == '0);
        req.lvl = empty;
        req.set = empty;
        req.clr = ({1'b0, tx_count} >= FULL_MARK);
    end
endmodule

// File: rtl/dma_rdy_pin.sv
module dma_rdy_pin
    import dma_rdy_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sig_style_e style,
    input  pin_req_t   req,
    output logic       rdy_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_n <= 1'b1;
        end else if (style == SIG_LEVEL) begin
            rdy_n <= !req.lvl;
        end else if (req.clr) begin
            rdy_n <= 1'b1;
        end else if (req.set) begin
            rdy_n <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_rdy_gen.sv
module dma_rdy_gen
    import dma_rdy_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             dma_mode,
    input  logic [1:0]       rx_trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_timeout,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rx_rdy_n,
    output logic             tx_rdy_n
);
    sig_style_e          style;
    pin_req_t            reqs [NUM_PINS];
    logic [NUM_PINS-1:0] pins_n;

    assign style = style_of(fifo_en, dma_mode);

    dma_rdy_rx_cond #(.CNT_W(CNT_W)) rx_cond_i (
        .rx_count    (rx_count),
        .rx_timeout  (rx_timeout),
        .rx_trig_sel (rx_trig_sel),
        .req         (reqs[RX_PIN])
    );

    dma_rdy_tx_cond #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) tx_cond_i (
        .tx_count (tx_count),
        .req      (reqs[TX_PIN])
    );

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
            dma_rdy_pin pin_i (
                .clk   (clk),
                .rst   (rst),
                .style (style),
                .req   (reqs[g]),
                .rdy_n (pins_n[g])
            );
        end
    endgenerate

    assign rx_rdy_n = pins_n[RX_PIN];
    assign tx_rdy_n = pins_n[TX_PIN];
endmodule

// File: rtl/dma_rdy_gen_chk.sv
module dma_rdy_gen_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             dma_mode,
    input logic [1:0]       rx_trig_sel,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_timeout,
    input logic [CNT_W-1:0] tx_count,
    input logic             rx_rdy_n,
    input logic             tx_rdy_n
);
    logic latched;
    logic at_trig;
    assign latched = fifo_en & dma_mode;
    assign at_trig = (rx_trig_sel == 2'b00 && rx_count >= CNT_W'(1))
                  || (rx_trig_sel == 2'b01 && rx_count >= CNT_W'(4))
                  || (rx_trig_sel == 2'b10 && rx_count >= CNT_W'(8))
                  || (rx_trig_sel == 2'b11 && rx_count >= CNT_W'(14));

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (rx_rdy_n && tx_rdy_n));

    // R3
    a_r3_rx_level: assert property (@(posedge clk) disable iff (rst)
        !latched |=> (rx_rdy_n == ($past(rx_count) == '0)));

    // R4
    a_r4_rx_trigger: assert property (@(posedge clk) disable iff (rst)
        (latched && at_trig) |=> !rx_rdy_n);

    // R5
    a_r5_rx_timeout: assert property (@(posedge clk) disable iff (rst)
        (latched && rx_timeout && rx_count != '0) |=> !rx_rdy_n);

    // R6
    a_r6_rx_drain: assert property (@(posedge clk) disable iff (rst)
        (latched && rx_count == '0) |=> rx_rdy_n);

    // R7
    a_r7_tx_level: assert property (@(posedge clk) disable iff (rst)
        !latched |=> (tx_rdy_n == ($past(tx_count) != '0)));

    // R8
    a_r8_tx_full: assert property (@(posedge clk) disable iff (rst)
        (latched && tx_count == CNT_W'(FIFO_DEPTH)) |=> tx_rdy_n);

    a_r8_tx_empty: assert property (@(posedge clk) disable iff (rst)
        (latched && tx_count == '0) |=> !tx_rdy_n);

    a_r8_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (latched && tx_count != '0 && tx_count != CNT_W'(FIFO_DEPTH))
            |=> (tx_rdy_n == $past(tx_rdy_n)));
endmodule

bind dma_rdy_gen dma_rdy_gen_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .fifo_en     (fifo_en),
    .dma_mode    (dma_mode),
    .rx_trig_sel (rx_trig_sel),
    .rx_count    (rx_count),
    .rx_timeout  (rx_timeout),
    .tx_count    (tx_count),
    .rx_rdy_n    (rx_rdy_n),
    .tx_rdy_n    (tx_rdy_n)
);

// File: tb/dma_rdy_gen_tb.sv
module dma_rdy_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CW         = 5;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic          fen;
        logic          dm;
        logic [1:0]    trig;
        logic [CW-1:0] rxc;
        logic          to;
        logic [CW-1:0] txc;
        logic          erx;
        logic          etx;
        logic [3:0]    rreq;
        logic [3:0]    treq;
    } vec_t;

    localparam int NV = 22;
    // Each row: inputs for one cycle, expected pins after the next edge.
    localparam vec_t VECS [NV] = '{
        // level style, FIFOs off: R3 R7
        '{1'b0, 1'b0, 2'b00, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0, 4'd3, 4'd7},
        '{1'b0, 1'b0, 2'b00, 5'd1,  1'b0, 5'd1,  1'b0, 1'b1, 4'd3, 4'd7},
        '{1'b0, 1'b0, 2'b00, 5'd0,  1'b0, 5'd3,  1'b1, 1'b1, 4'd3, 4'd7},
        // FIFOs on, DMA select off; and DMA select without FIFOs: R2
        '{1'b1, 1'b0, 2'b11, 5'd5,  1'b0, 5'd0,  1'b0, 1'b0, 4'd2, 4'd2},
        '{1'b0, 1'b1, 2'b01, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 4'd2, 4'd2},
        '{1'b0, 1'b1, 2'b01, 5'd2,  1'b0, 5'd16, 1'b0, 1'b1, 4'd2, 4'd2},
        '{1'b0, 1'b1, 2'b01, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0, 4'd2, 4'd2},
        // latched style, trigger 4: R4 R6 R8
        '{1'b1, 1'b1, 2'b01, 5'd3,  1'b0, 5'd5,  1'b1, 1'b0, 4'd4, 4'd8},
        '{1'b1, 1'b1, 2'b01, 5'd4,  1'b0, 5'd15, 1'b0, 1'b0, 4'd4, 4'd8},
        '{1'b1, 1'b1, 2'b01, 5'd2,  1'b0, 5'd16, 1'b0, 1'b1, 4'd6, 4'd8},
        '{1'b1, 1'b1, 2'b01, 5'd1,  1'b0, 5'd8,  1'b0, 1'b1, 4'd6, 4'd8},
        '{1'b1, 1'b1, 2'b01, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0, 4'd6, 4'd8},
        // trigger 1 and 8: R4
        '{1'b1, 1'b1, 2'b00, 5'd1,  1'b0, 5'd0,  1'b0, 1'b0, 4'd4, 4'd8},
        '{1'b1, 1'b1, 2'b00, 5'd0,  1'b0, 5'd16, 1'b1, 1'b1, 4'd6, 4'd8},
        '{1'b1, 1'b1, 2'b10, 5'd7,  1'b0, 5'd16, 1'b1, 1'b1, 4'd4, 4'd8},
        '{1'b1, 1'b1, 2'b10, 5'd8,  1'b0, 5'd1,  1'b0, 1'b1, 4'd4, 4'd8},
        // trigger 14: R4 R6
        '{1'b1, 1'b1, 2'b11, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0, 4'd6, 4'd8},
        '{1'b1, 1'b1, 2'b11, 5'd13, 1'b0, 5'd0,  1'b1, 1'b0, 4'd4, 4'd8},
        '{1'b1, 1'b1, 2'b11, 5'd14, 1'b0, 5'd0,  1'b0, 1'b0, 4'd4, 4'd8},
        // timeout: R5, empty beats timeout: R6
        '{1'b1, 1'b1, 2'b11, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0, 4'd6, 4'd8},
        '{1'b1, 1'b1, 2'b11, 5'd2,  1'b1, 5'd0,  1'b0, 1'b0, 4'd5, 4'd8},
        '{1'b1, 1'b1, 2'b11, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 4'd6, 4'd8}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fifo_en = 1'b0;
    logic          dma_mode = 1'b0;
    logic [1:0]    rx_trig_sel = 2'b00;
    logic [CW-1:0] rx_count = '0;
    logic          rx_timeout = 1'b0;
    logic [CW-1:0] tx_count = '0;
    logic          rx_rdy_n;
    logic          tx_rdy_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_rdy_gen #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .fifo_en     (fifo_en),
        .dma_mode    (dma_mode),
        .rx_trig_sel (rx_trig_sel),
        .rx_count    (rx_count),
        .rx_timeout  (rx_timeout),
        .tx_count    (tx_count),
        .rx_rdy_n    (rx_rdy_n),
        .tx_rdy_n    (tx_rdy_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic fen, input logic dm, input logic [1:0] trig,
                         input logic [CW-1:0] rxc, input logic to, input logic [CW-1:0] txc);
        fifo_en = fen; dma_mode = dm; rx_trig_sel = trig;
        rx_count = rxc; rx_timeout = to; tx_count = txc;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", rx_rdy_n, 1'b1);
        check("R1", tx_rdy_n, 1'b1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].fen, VECS[i].dm, VECS[i].trig, VECS[i].rxc, VECS[i].to, VECS[i].txc);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[i].rreq, i), rx_rdy_n, VECS[i].erx);
            check($sformatf("R%0d vec%0d", VECS[i].treq, i), tx_rdy_n, VECS[i].etx);
        end

        // R9: pins hold until the next rising edge
        drive(1'b1, 1'b1, 2'b00, 5'd3, 1'b0, 5'd16);
        #1;
        check("R9", rx_rdy_n, 1'b1);
        check("R9", tx_rdy_n, 1'b0);
        @(negedge clk);
        check("R9", rx_rdy_n, 1'b0);
        check("R9", tx_rdy_n, 1'b1);

        // R8: drain from full holds high until empty
        drive(1'b1, 1'b1, 2'b00, 5'd3, 1'b0, 5'd1);
        @(negedge clk);
        check("R8", tx_rdy_n, 1'b1);

        // R2: leaving latched style mid-hold follows the level rule
        drive(1'b1, 1'b0, 2'b00, 5'd3, 1'b0, 5'd1);
        @(negedge clk);
        check("R2", tx_rdy_n, 1'b1);
        check("R2", rx_rdy_n, 1'b0);
        drive(1'b1, 1'b1, 2'b00, 5'd3, 1'b0, 5'd0);
        @(negedge clk);
        check("R8", tx_rdy_n, 1'b0);

        // R1: reset while both pins are low
        rst = 1'b1;
        @(negedge clk);
        check("R1", rx_rdy_n, 1'b1);
        check("R1", tx_rdy_n, 1'b1);
        rst = 1'b0;
        drive(1'b1, 1'b1, 2'b01, 5'd2, 1'b0, 5'd4);
        @(negedge clk);
        check("R4", rx_rdy_n, 1'b1);
        check("R8", tx_rdy_n, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule